// File: doc/BRIEF.md
# Streaming Sobel Edge Magnitude Kernel

This block is a pipelined image filter. It takes 8-bit grayscale pixels in raster order, one per clock, over a valid/ready input stream. For each pixel it sends one 8-bit edge-strength pixel out over a valid/ready output stream. It keeps the two previous image rows in internal line memories and a 3x3 window of registers. From the window centre it computes the horizontal and vertical Sobel gradients and outputs the sum of their magnitudes, clipped to 255. Pixels on the outer border of the image have no full neighbourhood, so the block outputs 0 for them.

The output stream runs IMG_W+1 pixels behind the input stream. This is the distance from a centre pixel to the last pixel of its neighbourhood. After reset, the first IMG_W+1 pixels accepted only fill the line memories. From then on, every accepted pixel releases exactly one output, and outputs come out in raster order of the centre pixels. Frames may follow each other with no gap: the position counters wrap at the image edges, so the first IMG_W+1 pixels of the next frame (or dummy pixels) push out the tail of the previous frame. The pipeline advances as one unit. If the output holds a result the receiver does not take, every stage and the input freeze.

Top module: `sobel_edge_stream`

## Requirements
- R1: When edgeOutReady is held high, pixInReady is high on every cycle, so one pixel is accepted each clock (initiation interval of one).
- R2: After reset, the first IMG_W+1 accepted pixels produce no output. Each accepted pixel after that produces exactly one output, in raster order of centre pixels. No output appears that has no pixel to cause it.
- R3: Rows are numbered from 0 (top) and columns from 0 (left), and pixels arrive row-major. A centre pixel in row 0, row IMG_H-1, column 0 or column IMG_W-1 gives output 0.
- R4: For an interior centre, the output is min(255, |Gx|+|Gy|). Gx takes the right column minus the left column of the 3x3 neighbourhood, with weights 1,2,1 from top to bottom. Gy takes the bottom row minus the top row, with weights 1,2,1 from left to right.
- R5: While edgeOutValid is high and edgeOutReady is low, edgeOutValid stays high and edgeOutData stays unchanged on the next cycle.
- R6: pixInReady is low only in a cycle where edgeOutValid is high and edgeOutReady is low. During such a stall, no pixel is accepted and the pipeline holds at most three results.
- R7: Frames may follow each other back to back. The column and row positions wrap at IMG_W-1 and IMG_H-1. The first IMG_W+1 pixels of the next stream segment release the last outputs of the previous frame.
- R8: While reset (rst_n low) is applied and right after it, edgeOutValid is low and pixInReady is high.
- R9: With no stalls, the output for a centre becomes valid after the second rising edge that follows the edge that accepted the last pixel of its neighbourhood (three register stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pixInValid | input | 1 | Input pixel present |
| pixInReady | output | 1 | Block accepts the input pixel this cycle |
| pixInData | input | 8 | Grayscale input pixel |
| edgeOutValid | output | 1 | Output pixel present |
| edgeOutReady | input | 1 | Receiver takes the output pixel this cycle |
| edgeOutData | output | 8 | Edge magnitude output pixel |

## Verification
On every cycle, the assertions check the handshake rules: output hold under back-pressure, input stall only when the output is blocked, and a ready receiver never stalling the input. They also check that outputs stay at least IMG_W+1 pixels behind inputs, that border outputs are zero (using an output position counter of their own), and the idle state after reset. Only the bench scenarios can show that the gradient values are correct for interior pixels, that clipping happens at 255, and that frames chain correctly across the frame boundary. The same holds for the exact three-stage latency, the fill depth before the first output, and how many pixels a blocked pipeline takes in.

// File: rtl/sobel_edge_pkg.sv
`timescale 1ns/1ps
package sobel_edge_pkg;

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic advance;  // whole pipeline moves one step
    logic push;     // a new pixel enters line memories and window
    logic zeroS2;   // gradient stage holds a border centre
  } sobelStrobe_t;

  localparam int KERNEL = 3;

endpackage

// File: rtl/sobel_ctrl.sv
`timescale 1ns/1ps
module sobel_ctrl
  import sobel_edge_pkg::*;
#(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pixInValid,
  input  logic                       edgeOutReady,
  output logic                       pixInReady,
  output logic                       edgeOutValid,
  output logic [$clog2(IMG_W)-1:0]   colIdx,
  output sobelStrobe_t               strobe
);

  localparam int COL_W  = $clog2(IMG_W);
  localparam int ROW_W  = $clog2(IMG_H);
  localparam int FILL   = IMG_W + 1;
  localparam int FILL_W = $clog2(FILL + 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(IMG_H - 1);

  logic [COL_W-1:0]  inCol;
  logic [COL_W-1:0]  cCol;
  logic [ROW_W-1:0]  cRow;
  logic [FILL_W-1:0] fillCnt;
  logic              primed;
  logic              centreBorder;
  logic              advance;
  logic              push;
  logic              s1Vld, s1Bord, s2Vld, s2Bord, outVld;

  assign advance      = !outVld || edgeOutReady;
  assign push         = pixInValid && advance;
  assign primed       = (fillCnt == FILL_W'(FILL));
  assign centreBorder = (cRow == '0) || (cRow == LAST_ROW) ||
                        (cCol == '0) || (cCol == LAST_COL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inCol   <= '0;
      cCol    <= '0;
      cRow    <= '0;
      fillCnt <= '0;
      s1Vld   <= 1'b0;
      s1Bord  <= 1'b0;
      s2Vld   <= 1'b0;
      s2Bord  <= 1'b0;
      outVld  <= 1'b0;
    end else begin
      if (push) begin
        inCol <= (inCol == LAST_COL) ? '0 : inCol + 1'b1;
      end
      if (push && !primed) begin
        fillCnt <= fillCnt + 1'b1;
      end
      if (push && primed) begin
        if (cCol == LAST_COL) begin
          cCol <= '0;
          cRow <= (cRow == LAST_ROW) ? '0 : cRow + 1'b1;
        end else begin
          cCol <= cCol + 1'b1;
        end
      end
      if (advance) begin
        s1Vld  <= push && primed;
        s1Bord <= centreBorder;
        s2Vld  <= s1Vld;
        s2Bord <= s1Bord;
        outVld <= s2Vld;
      end
    end
  end

  assign pixInReady     = advance;
  assign edgeOutValid   = outVld;
  assign colIdx         = inCol;
  assign strobe.advance = advance;
  assign strobe.push    = push;
  assign strobe.zeroS2  = s2Bord;

endmodule

// File: rtl/sobel_datapath.sv
`timescale 1ns/1ps
module sobel_datapath
  import sobel_edge_pkg::*;
#(
  parameter int IMG_W = 512,
  parameter int PIX_W = 8
) (
  input  logic                      clk,
  input  sobelStrobe_t              strobe,
  input  logic [$clog2(IMG_W)-1:0]  colIdx,
  input  logic [PIX_W-1:0]          pixIn,
  output logic [PIX_W-1:0]          edgeOut
);

  localparam int TAPS   = KERNEL - 1;
  localparam int GRAD_W = PIX_W + 3;
  localparam int MAG_W  = GRAD_W + 1;
  localparam logic [MAG_W-1:0] PIX_MAX = MAG_W'((1 << PIX_W) - 1);

  logic [PIX_W-1:0] tapIn [TAPS+1];
  logic [PIX_W-1:0] win [KERNEL][KERNEL];
  logic signed [GRAD_W-1:0] gxNext, gyNext, gxReg, gyReg;
  logic [GRAD_W-1:0] gxAbs, gyAbs;
  logic [MAG_W-1:0]  magSum;
  logic [PIX_W-1:0]  outReg;

  assign tapIn[0] = pixIn;

  // One line memory per previous row; each feeds the next.
  for (genvar t = 0; t < TAPS; t++) begin : gLine
    logic [PIX_W-1:0] mem [IMG_W];
    always_ff @(posedge clk) begin
      if (strobe.push) begin
        mem[colIdx] <= tapIn[t];
      end
    end
    assign tapIn[t+1] = mem[colIdx];
  end

  // Window: row 0 is the oldest row, column KERNEL-1 the newest column.
  always_ff @(posedge clk) begin
    if (strobe.push) begin
      for (int rr = 0; rr < KERNEL; rr++) begin
        for (int cc = 0; cc < KERNEL - 1; cc++) begin
          win[rr][cc] <= win[rr][cc+1];
        end
        win[rr][KERNEL-1] <= tapIn[KERNEL-1-rr];
      end
    end
  end

  function automatic logic signed [GRAD_W-1:0] ext(input logic [PIX_W-1:0] p);
    return $signed({3'b000, p});
  endfunction

  always_comb begin
    gxNext = (ext(win[0][2]) + (ext(win[1][2]) <<< 1) + ext(win[2][2]))
           - (ext(win[0][0]) + (ext(win[1][0]) <<< 1) + ext(win[2][0]));
    gyNext = (ext(win[2][0]) + (ext(win[2][1]) <<< 1) + ext(win[2][2]))
           - (ext(win[0][0]) + (ext(win[0][1]) <<< 1) + ext(win[0][2]));
  end

  always_comb begin
    gxAbs  = gxReg[GRAD_W-1] ? GRAD_W'(-gxReg) : GRAD_W'(gxReg);
    gyAbs  = gyReg[GRAD_W-1] ? GRAD_W'(-gyReg) : GRAD_W'(gyReg);
    magSum = {1'b0, gxAbs} + {1'b0, gyAbs};
  end

  always_ff @(posedge clk) begin
    if (strobe.advance) begin
      gxReg <= gxNext;
      gyReg <= gyNext;
      if (strobe.zeroS2) begin
        outReg <= '0;
      end else if (magSum > PIX_MAX) begin
        outReg <= PIX_MAX[PIX_W-1:0];
      end else begin
        outReg <= magSum[PIX_W-1:0];
      end
    end
  end

  assign edgeOut = outReg;

endmodule

// File: rtl/sobel_edge_stream.sv
`timescale 1ns/1ps
module sobel_edge_stream
  import sobel_edge_pkg::*;
#(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pixInValid,
  output logic       pixInReady,
  input  logic [7:0] pixInData,
  output logic       edgeOutValid,
  input  logic       edgeOutReady,
  output logic [7:0] edgeOutData
);

  localparam int COL_W = $clog2(IMG_W);

  sobelStrobe_t     strobe;
  logic [COL_W-1:0] colIdx;

  sobel_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) uCtrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .pixInValid   (pixInValid),
    .edgeOutReady (edgeOutReady),
    .pixInReady   (pixInReady),
    .edgeOutValid (edgeOutValid),
    .colIdx       (colIdx),
    .strobe       (strobe)
  );

  sobel_datapath #(.IMG_W(IMG_W), .PIX_W(8)) uData (
    .clk     (clk),
    .strobe  (strobe),
    .colIdx  (colIdx),
    .pixIn   (pixInData),
    .edgeOut (edgeOutData)
  );

endmodule

// File: rtl/sobel_edge_stream_chk.sv
`timescale 1ns/1ps
module sobel_edge_stream_chk #(
  parameter int IMG_W = 512,
  parameter int IMG_H = 512
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pixInValid,
  input logic       pixInReady,
  input logic [7:0] pixInData,
  input logic       edgeOutValid,
  input logic       edgeOutReady,
  input logic [7:0] edgeOutData
);

  logic [31:0] inCnt, outCnt, outCol, outRow;
  logic        outAtBorder;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inCnt  <= '0;
      outCnt <= '0;
      outCol <= '0;
      outRow <= '0;
    end else begin
      if (pixInValid && pixInReady) inCnt <= inCnt + 1;
      if (edgeOutValid && edgeOutReady) begin
        outCnt <= outCnt + 1;
        if (outCol == 32'(IMG_W - 1)) begin
          outCol <= '0;
          outRow <= (outRow == 32'(IMG_H - 1)) ? '0 : outRow + 1;
        end else begin
          outCol <= outCol + 1;
        end
      end
    end
  end

  assign outAtBorder = (outRow == 0) || (outRow == 32'(IMG_H - 1)) ||
                       (outCol == 0) || (outCol == 32'(IMG_W - 1));

  AST_READY_WHEN_SINK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    edgeOutReady |-> pixInReady); // R1
  AST_OUT_BEHIND_IN: assert property (@(posedge clk) disable iff (!rst_n)
    edgeOutValid |-> (inCnt >= outCnt + 32'(IMG_W + 2))); // R2
  AST_BORDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeOutValid && outAtBorder) |-> (edgeOutData == 8'd0)); // R3
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeOutValid && !edgeOutReady) |=> edgeOutValid); // R5
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeOutValid && !edgeOutReady) |=> $stable(edgeOutData)); // R5
  AST_STALL_ONLY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !pixInReady |-> (edgeOutValid && !edgeOutReady)); // R6
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> !edgeOutValid); // R8

endmodule

bind sobel_edge_stream sobel_edge_stream_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) uChk (.*);

// File: tb/sobel_edge_stream_test.sv
`timescale 1ns/1ps
module sobel_edge_stream_test;

  localparam int W      = 6;
  localparam int H      = 5;
  localparam int FRAME  = W * H;
  localparam int NFRM   = 3;
  localparam int N_EXP  = FRAME * NFRM;
  localparam int N_IN   = N_EXP + W + 1;

  // Stimulus vectors for the first frame; later frames are generated.
  localparam logic [7:0] FRAME_A [FRAME] = '{
    8'd12,  8'd200, 8'd45,  8'd90,  8'd3,   8'd77,
    8'd130, 8'd18,  8'd250, 8'd66,  8'd101, 8'd9,
    8'd55,  8'd140, 8'd33,  8'd210, 8'd88,  8'd5,
    8'd240, 8'd61,  8'd120, 8'd199, 8'd14,  8'd70,
    8'd30,  8'd150, 8'd95,  8'd180, 8'd40,  8'd222
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pixInValid = 1'b0;
  logic       pixInReady;
  logic [7:0] pixInData = 8'd0;
  logic       edgeOutValid;
  logic       edgeOutReady = 1'b0;
  logic [7:0] edgeOutData;

  int checks = 0;
  int errors = 0;
  logic [7:0] streamPix [N_IN];
  logic [7:0] expPix    [N_EXP];
  bit         expBorder [N_EXP];

  always #2.5 clk = ~clk;

  sobel_edge_stream #(.IMG_W(W), .IMG_H(H)) uut (
    .clk (clk), .rst_n (rst_n),
    .pixInValid (pixInValid), .pixInReady (pixInReady), .pixInData (pixInData),
    .edgeOutValid (edgeOutValid), .edgeOutReady (edgeOutReady), .edgeOutData (edgeOutData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; pixInValid = 1'b0; edgeOutReady = 1'b0;
    repeat (3) @(negedge clk);
    check(!edgeOutValid && pixInReady, "R8 reset state", {edgeOutValid, pixInReady}, 1);
    rst_n = 1'b1;
  endtask

  function automatic int px(int f, int r, int c);
    return int'(streamPix[f*FRAME + r*W + c]);
  endfunction

  task automatic buildVectors();
    for (int i = 0; i < N_IN; i++) begin
      int f = i / FRAME;
      int r = (i % FRAME) / W;
      int c = i % W;
      if (f == 0)      streamPix[i] = FRAME_A[i];
      else if (f == 1) streamPix[i] = (c >= 3) ? 8'd255 : 8'd0;
      else if (f == 2) streamPix[i] = 8'(r*10 + c*3);
      else             streamPix[i] = 8'd0;
    end
    for (int n = 0; n < N_EXP; n++) begin
      int f = n / FRAME;
      int r = (n % FRAME) / W;
      int c = n % W;
      expBorder[n] = (r == 0) || (r == H-1) || (c == 0) || (c == W-1);
      if (expBorder[n]) expPix[n] = 8'd0;
      else begin
        int gx = (px(f,r-1,c+1) + 2*px(f,r,c+1) + px(f,r+1,c+1))
               - (px(f,r-1,c-1) + 2*px(f,r,c-1) + px(f,r+1,c-1));
        int gy = (px(f,r+1,c-1) + 2*px(f,r+1,c) + px(f,r+1,c+1))
               - (px(f,r-1,c-1) + 2*px(f,r-1,c) + px(f,r-1,c+1));
        int m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
        expPix[n] = (m > 255) ? 8'd255 : 8'(m);
      end
    end
  endtask

  task automatic runStream(input bit useStall);
    int inIdx = 0;
    int outIdx = 0;
    int obs = 0;
    int firstValid = -1;
    int notReady = 0;
    bit holdPend = 0;
    logic [7:0] holdData = 8'd0;
    logic [15:0] lfsr = 16'hACE1;
    while (outIdx < N_EXP && obs < 4000) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pixInValid   = (inIdx < N_IN) && (!useStall || lfsr[0] || lfsr[3]);
      pixInData    = pixInValid ? streamPix[inIdx] : 8'd0;
      edgeOutReady = !useStall || lfsr[5] || lfsr[8];
      #1;
      if (holdPend)
        check(edgeOutValid && edgeOutData == holdData, "R5 hold under back-pressure",
              int'(edgeOutData), int'(holdData));
      holdPend = edgeOutValid && !edgeOutReady;
      holdData = edgeOutData;
      if (!useStall && !pixInReady) notReady++;
      if (edgeOutValid && firstValid < 0) firstValid = obs;
      if (edgeOutValid && edgeOutReady) begin
        if (outIdx >= FRAME)
          check(edgeOutData == expPix[outIdx], "R7 chained frame output",
                int'(edgeOutData), int'(expPix[outIdx]));
        else if (expBorder[outIdx])
          check(edgeOutData == expPix[outIdx], "R3 border output",
                int'(edgeOutData), int'(expPix[outIdx]));
        else
          check(edgeOutData == expPix[outIdx], "R4 interior magnitude",
                int'(edgeOutData), int'(expPix[outIdx]));
        outIdx++;
      end
      if (pixInValid && pixInReady) inIdx++;
      obs++;
    end
    check(outIdx == N_EXP, "R2 output count", outIdx, N_EXP);
    check(inIdx == N_IN, "R2 inputs consumed when last output left", inIdx, N_IN);
    if (!useStall) begin
      check(notReady == 0, "R1 ready every cycle", notReady, 0);
      check(firstValid == W + 4, "R9 first output cycle", firstValid, W + 4);
    end
    @(negedge clk);
    pixInValid = 1'b0;
    edgeOutReady = 1'b1;
    begin
      int extra = 0;
      repeat (6) begin
        @(negedge clk); #1;
        if (edgeOutValid) extra++;
      end
      check(extra == 0, "R2 no output without input", extra, 0);
    end
  endtask

  task automatic blockedTest();
    int taken = 0;
    logic [7:0] held;
    edgeOutReady = 1'b0;
    repeat (20) begin
      @(negedge clk);
      pixInValid = 1'b1;
      pixInData  = 8'd77;
      #1;
      if (pixInReady) taken++;
    end
    check(taken == W + 4, "R6 pixels taken while blocked", taken, W + 4);
    check(!pixInReady && edgeOutValid, "R6 input stalled", pixInReady, 0);
    held = edgeOutData;
    repeat (3) @(negedge clk);
    #1;
    check(edgeOutValid && edgeOutData == held, "R5 data frozen", int'(edgeOutData), int'(held));
    edgeOutReady = 1'b1;
    #1;
    check(pixInReady, "R6 ready returns with sink", pixInReady, 1);
    @(negedge clk);
    pixInValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    buildVectors();
    doReset();
    runStream(1'b0);
    doReset();
    runStream(1'b1);
    doReset();
    blockedTest();
    doReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule